// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Output Select

This block is an 8-bit reloadable down-counter governed by a 4-bit control nibble that can only be written. The nibble chooses what clocks the counter, and it has three choices: every system clock, one clock in every 64 taken from a free-running prescaler, or rising edges on an external pin. The same nibble starts and stops counting. Each time the counter passes through zero it reloads from a reload register and toggles a square-wave output. The result is a tick rate divided by twice (reload+1).

A single shared output pin is driven by a multiplexer. The last control bit selects whether the pin carries the timer square wave or a waveform supplied by a separate generator. Software can write a reload value at any time. While the timer is stopped, that write also presets the counter, so the first half-period after a start has full length.

Top module: `pulse_timer`

## Requirements
- R1: After a synchronous active-low reset, the control nibble, the counter, the reload value and the timer output are all zero. The timer is therefore stopped and the shared pin follows the generator input.
- R2: With bit 0 of the control nibble set and the internal source selected, the counter takes one tick every 64 system clocks. With bit 0 clear, it takes a tick every clock.
- R3: With bit 1 set, the counter takes exactly one tick for each rising edge on the external pin. The pin passes through a two-flop synchronizer, so the tick reaches the counter on the third clock edge after the pin rises.
- R4: Bit 2 selects the source of the shared pin. When bit 2 is 0, the pin equals the generator input in the same cycle. When bit 2 is 1, the pin carries the timer output.
- R5: While bit 3 is 0, the counter and the timer output hold their values.
- R6: While bit 3 is 1, each tick lowers a nonzero count by one. A tick at count zero reloads the counter and toggles the timer output. Consecutive toggles are therefore reload+1 ticks apart.
- R7: A reload write while stopped also loads the counter on the same clock edge. A reload write while running changes only the value used at the next reload.
- R8: A control write takes effect on the clock edge that captures it and governs behaviour from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Control nibble write strobe |
| mode_wdata | input | 4 | Control nibble: bit0 slow tick, bit1 external source, bit2 timer-to-pin, bit3 run |
| reload_we | input | 1 | Reload value write strobe |
| reload_wdata | input | 8 | Reload value |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| gen_wave_in | input | 1 | Waveform from the separate generator |
| shared_out | output | 1 | Shared output pin |

## Verification
The counter cannot be read back, so a wrong count, a wrong reload or a wrong prescaler phase shows up only as a misplaced edge on the shared pin. That edge appears within one half-period, which is at most 256 ticks after the fault. A stuck select bit or a bad run gate shows up on the pin in the very next cycle. A cycle-by-cycle reference model compares the pin on every clock under random control, reload and pin activity. Directed runs then measure half-periods at full rate and at the /64 rate, and count the toggles caused by external edges.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the down-counting timer.
package tmr_pkg;
    // Control nibble; field order follows the written bit positions (bit3..bit0).
    typedef struct packed {
        logic run;        // bit 3: counter advances
        logic pin_timer;  // bit 2: shared pin carries timer output
        logic ext_src;    // bit 1: tick from external pin
        logic slow;       // bit 0: internal tick divided by 2**PRE_W
    } tmr_mode_t;

    localparam int MODE_W = $bits(tmr_mode_t);
endpackage

// File: rtl/tmr_prescale.sv
// Free-running prescaler: emits a one-cycle pulse every 2**PRE_W clocks.
// Assumes: clk is the system clock; rst_n synchronous active-low.
module tmr_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [PRE_W-1:0] WRAP = '1;

    logic [PRE_W-1:0] div_q;

    // Advance the free-running divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == WRAP);

    // R2: a prescaler pulse never lasts more than one cycle.
    p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_ext_edge.sv
// Synchronizes an asynchronous pin through STAGES flops and flags rising edges.
// Assumes: the pin stays stable for at least one clock per level.
module tmr_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R3: one rising edge yields a single-cycle pulse.
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_downcount.sv
// Reloadable down-counter whose output toggles on every reload.
// Assumes: tick is a one-cycle enable already gated by the run bit.
module tmr_downcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    output logic             wave
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rel_q;

    // Capture the reload value whenever it is written.
    always_ff @(posedge clk) begin
        if (!rst_n)         rel_q <= '0;
        else if (reload_we) rel_q <= reload_wdata;
    end

    // Preset while stopped, else count down, reload and toggle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else if (!run) begin
            if (reload_we) cnt_q <= reload_wdata;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= rel_q;
                wave  <= ~wave;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R5: stopped and unwritten, the state is frozen.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_we) |=> ($stable(cnt_q) && $stable(wave)));
    // R6: a tick at zero flips the output.
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_q == '0) |=> (wave != $past(wave)));
    // R6: without a tick the output never changes.
    p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(wave));
    // R7: a stopped reload write presets the counter.
    p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && reload_we) |=> (cnt_q == $past(reload_wdata)));
endmodule

// File: rtl/pulse_timer.sv
// Top: control nibble, tick source selection and shared output pin multiplexer.
// Assumes: gen_wave_in is synchronous to clk; ext_clk_in may be asynchronous.
module pulse_timer #(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [3:0]       mode_wdata,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             ext_clk_in,
    input  logic             gen_wave_in,
    output logic             shared_out
);
    import tmr_pkg::*;

    tmr_mode_t mode_q;
    logic      div_tick;
    logic      ext_rise;
    logic      base_tick;
    logic      cnt_tick;
    logic      wave;

    // Hold the write-only control nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= tmr_mode_t'(mode_wdata[MODE_W-1:0]);
    end

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk (clk), .rst_n (rst_n), .tick (div_tick)
    );

    tmr_ext_edge #(.STAGES(STAGES)) u_ext (
        .clk (clk), .rst_n (rst_n), .pin (ext_clk_in), .rise (ext_rise)
    );

    // Pick the tick source and gate it with run.
    always_comb begin
        base_tick = mode_q.slow ? div_tick : 1'b1;
        cnt_tick  = mode_q.run & (mode_q.ext_src ? ext_rise : base_tick);
    end

    tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (mode_q.run),
        .tick         (cnt_tick),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .wave         (wave)
    );

    // Route timer or generator waveform to the shared pin.
    assign shared_out = mode_q.pin_timer ? wave : gen_wave_in;

    // R1: the cycle after reset the generator owns the pin.
    p_reset_sel_r1: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (shared_out == gen_wave_in));
    // R8: a captured control write is visible on the next cycle.
    p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q == $past(mode_wdata)));
endmodule

// File: tb/pulse_timer_test.sv
module pulse_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic       reload_we = 1'b0;
    logic [7:0] reload_wdata = '0;
    logic       ext_clk_in = 1'b0;
    logic       gen_wave_in = 1'b0;
    logic       shared_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    pulse_timer uut (
        .clk (clk), .rst_n (rst_n), .mode_we (mode_we), .mode_wdata (mode_wdata),
        .reload_we (reload_we), .reload_wdata (reload_wdata),
        .ext_clk_in (ext_clk_in), .gen_wave_in (gen_wave_in), .shared_out (shared_out)
    );

    // Reference model built from the requirements.
    logic [3:0] m_mode;
    logic [5:0] m_div;
    logic [2:0] m_sh;
    logic [7:0] m_cnt, m_rel;
    logic       m_wave;

    function automatic logic tick_of(logic [3:0] md, logic [5:0] dv, logic [2:0] sh);
        logic t;
        if (md[1]) t = sh[1] & ~sh[2];
        else       t = md[0] ? (dv == 6'd63) : 1'b1;
        return md[3] & t;
    endfunction

    function automatic logic exp_pin(logic [3:0] md, logic wv, logic g);
        return md[2] ? wv : g;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= '0; m_div <= '0; m_sh <= '0;
            m_cnt <= '0; m_rel <= '0; m_wave <= 1'b0;
        end else begin
            if (mode_we) m_mode <= mode_wdata;
            m_div <= m_div + 1'b1;
            m_sh  <= {m_sh[1:0], ext_clk_in};
            if (reload_we) m_rel <= reload_wdata;
            if (!m_mode[3]) begin
                if (reload_we) m_cnt <= reload_wdata;
            end else if (tick_of(m_mode, m_div, m_sh)) begin
                if (m_cnt == 0) begin m_cnt <= m_rel; m_wave <= ~m_wave; end
                else m_cnt <= m_cnt - 1'b1;
            end
        end
    end

    task automatic check(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Advance to the next falling edge and compare the pin with the model.
    task automatic step(string req);
        @(negedge clk);
        check(req, shared_out, exp_pin(m_mode, m_wave, gen_wave_in));
        mode_we = 1'b0; reload_we = 1'b0;
    endtask

    task automatic wr_mode(logic [3:0] v);
        mode_we = 1'b1; mode_wdata = v; step("R8");
    endtask

    task automatic wr_rel(logic [7:0] v);
        reload_we = 1'b1; reload_wdata = v; step("R7");
    endtask

    // Cycles between two successive pin changes.
    task automatic half_period(string req, int limit, output int gap);
        logic prev;
        int   c;
        prev = shared_out;
        c = 0;
        while (shared_out == prev && c < limit) begin step(req); c++; end
        prev = shared_out;
        c = 0;
        while (shared_out == prev && c < limit) begin step(req); c++; end
        gap = c;
    endtask

    initial begin
        int gap;
        int edges;
        logic w0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: generator owns the pin after reset, both levels.
        gen_wave_in = 1'b0; #1 check("R1", shared_out, 1'b0);
        gen_wave_in = 1'b1; #1 check("R1", shared_out, 1'b1);
        // R4: generator passes through in the same cycle.
        gen_wave_in = 1'b0; #1 check("R4", shared_out, 1'b0);
        // R1: timer output starts low when selected with run off.
        wr_mode(4'b0100);
        check("R1", shared_out, 1'b0);

        // R7/R6: preset 3 while stopped, run at full rate -> half-period 4.
        wr_rel(8'd3);
        wr_mode(4'b1100);
        half_period("R6", 50, gap);
        check_int("R6", gap, 4);
        // R7: running reload write applies at next reload -> gap 6 later.
        wr_rel(8'd5);
        half_period("R7", 50, gap);
        half_period("R7", 50, gap);
        check_int("R7", gap, 6);

        // R5: stop and confirm the pin is frozen.
        wr_mode(4'b0100);
        w0 = shared_out;
        repeat (40) step("R5");
        check("R5", shared_out, w0);

        // R2: reload 0 with /64 prescale -> half-period 64.
        wr_rel(8'd0);
        wr_mode(4'b1101);
        half_period("R2", 300, gap);
        check_int("R2", gap, 64);

        // R3: external source, reload 0 -> one toggle per rising edge.
        wr_mode(4'b0110);
        wr_mode(4'b1110);
        repeat (5) step("R3");
        w0 = shared_out;
        edges = 0;
        for (int k = 0; k < 6; k++) begin
            ext_clk_in = 1'b1; repeat (4) step("R3");
            if (shared_out != w0) edges++;
            w0 = shared_out;
            ext_clk_in = 1'b0; repeat (4) step("R3");
        end
        check_int("R3", edges, 6);
        // R3: a high level held without new edges adds no toggle.
        ext_clk_in = 1'b1; repeat (4) step("R3");
        w0 = shared_out;
        repeat (20) step("R3");
        check("R3", shared_out, w0);

        // Random mix compared against the model every cycle.
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                mode_we = 1'b1; mode_wdata = 4'($urandom);
            end
            if ($urandom_range(0, 29) == 0) begin
                reload_we = 1'b1; reload_wdata = 8'($urandom_range(0, 9));
            end
            if ($urandom_range(0, 3) == 0) ext_clk_in = ~ext_clk_in;
            if ($urandom_range(0, 2) == 0) gen_wave_in = ~gen_wave_in;
            step(m_mode[2] ? "R6" : "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule